// File: doc/BRIEF.md
# Predicate mask fetch sequencer

This block prepares the predicate masks a vector instruction needs before its first element is issued. A single `start` pulse latches the configuration: the predicate kind (integer register or condition-register fields), single or twin predication, and for each of the source and destination masks a register specifier, a condition-bit selector and an invert flag, together with the vector length. The block then reads the masks through its own read ports and raises `done` for one cycle when both masks are complete.

An integer predicate takes one read of one integer register, and the low mask bits are taken from it. Specifier zero means "always", so the mask is all ones and no read is made. A condition-register predicate is built one element per cycle. For element i, field (specifier + i) is read, one of its four flag bits is picked and optionally inverted, and the result goes into mask bit i. In single mode the destination mask is a copy of the source mask. Mask bits at or above the vector length are always zero.

Top module: `pred_mask_fetch`

## Requirements
- R1: After reset `done` is 0, both masks are 0 and neither read enable is asserted.
- R2: In integer mode with a nonzero specifier, the source mask equals the low MAX_VL bits of integer register `src_spec[4:0]`, read once. In single mode `done` rises 2 cycles after the accepting clock edge.
- R3: In condition mode, element i reads field `(spec + i) mod 64`, one field per cycle. The 4-bit field data is ordered as bit3 = LT, bit2 = GT, bit1 = EQ and bit0 = SO. The selector values are 0 = LT, 1 = GT, 2 = EQ and 3 = SO. Mask bit i is the selected flag XOR the invert flag. A single-mode fetch takes max(VL,1)+1 cycles to `done`.
- R4: In integer mode a specifier whose low 5 bits are zero yields an all-ones mask (within VL) without any integer read.
- R5: In twin mode the destination mask is fetched after the source mask with its own specifier, selector and invert. An integer twin fetch makes two reads and completes in 3 cycles. A condition twin fetch completes in 2*max(VL,1)+1 cycles.
- R6: In single mode the destination mask equals the source mask.
- R7: Mask bits at positions at or above VL are zero. With VL = 0 both masks are zero and a condition fetch makes no reads.
- R8: `done` is a one-cycle pulse, and both masks stay unchanged after it until the next accepted start.
- R9: A `start` pulse while a fetch is in progress is ignored: the running fetch's masks are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| use_cr | input | 1 | 1 = condition-field predicate, 0 = integer predicate |
| twin | input | 1 | 1 = separate destination mask |
| vl | input | VLW | Vector length, 0..MAX_VL |
| src_spec | input | SPW | Source register number or base field |
| src_sel | input | 2 | Source flag selector |
| src_inv | input | 1 | Source invert flag |
| dst_spec | input | SPW | Destination register number or base field |
| dst_sel | input | 2 | Destination flag selector |
| dst_inv | input | 1 | Destination invert flag |
| int_rd_en | output | 1 | Integer predicate read enable |
| int_rd_addr | output | IRW | Integer register number |
| int_rd_data | input | XLEN | Integer read data, same cycle |
| cr_rd_en | output | 1 | Condition-field read enable |
| cr_rd_addr | output | CRW | Condition field number |
| cr_rd_data | input | 4 | Field flags LT,GT,EQ,SO (bit3..bit0) |
| src_mask | output | MAX_VL | Source predicate mask |
| dst_mask | output | MAX_VL | Destination predicate mask |
| done | output | 1 | Masks complete (one-cycle pulse) |

## Verification
Some properties are checked by the assertions on every cycle. The two read ports are never active together, and an integer read never targets register zero. Consecutive condition reads within one mask step through adjacent field numbers. `done` never lasts two cycles, a completed mask has no bit set at or above VL, and a single-mode destination matches its source. Only the bench scenarios show the rest: the actual mask values against modelled register contents, read counts and latencies, field wrap-around, inversion, VL of zero, and a start arriving mid-fetch being ignored.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FETCH_SRC = 2'd1,
    ST_FETCH_DST = 2'd2,
    ST_DONE      = 2'd3
  } pmf_state_e;

  // flag order inside a field: bit3 LT, bit2 GT, bit1 EQ, bit0 SO
  function automatic logic cr_pick(input logic [3:0] field,
                                   input logic [1:0] sel,
                                   input logic inv);
    logic b;
    case (sel)
      2'd0:    b = field[3];
      2'd1:    b = field[2];
      2'd2:    b = field[1];
      default: b = field[0];
    endcase
    return b ^ inv;
  endfunction
endpackage

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
  import pmf_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int IRW    = 5,
  parameter int CRW    = 6,
  parameter int SPW    = 6,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           use_cr,
  input  logic           twin,
  input  logic [VLW-1:0] vl,
  input  logic [SPW-1:0] src_spec,
  input  logic [1:0]     src_sel,
  input  logic           src_inv,
  input  logic [SPW-1:0] dst_spec,
  input  logic [1:0]     dst_sel,
  input  logic           dst_inv,
  input  logic [3:0]     cr_rd_data,
  output logic           int_rd_en,
  output logic [IRW-1:0] int_rd_addr,
  output logic           cr_rd_en,
  output logic [CRW-1:0] cr_rd_addr,
  output logic           accept,
  output logic [VLW-1:0] vl_eff,
  output logic           twin_eff,
  output logic           wr_int,
  output logic           wr_cr,
  output logic           wr_dst,
  output logic           all_ones,
  output logic           cr_bit,
  output logic [VLW-1:0] elem,
  output logic           fin
);
  pmf_state_e     state_q, state_d;
  logic [VLW-1:0] elem_q, vl_q;
  logic           cr_q, twin_q;
  logic [SPW-1:0] sspec_q, dspec_q;
  logic [1:0]     ssel_q, dsel_q;
  logic           sinv_q, dinv_q;
  logic [SPW-1:0] cur_spec;
  logic [1:0]     cur_sel;
  logic           cur_inv;
  logic           fetching, step_last;

  assign accept   = start && (state_q == ST_IDLE);
  assign fetching = (state_q == ST_FETCH_SRC) || (state_q == ST_FETCH_DST);
  assign wr_dst   = (state_q == ST_FETCH_DST);
  assign cur_spec = wr_dst ? dspec_q : sspec_q;
  assign cur_sel  = wr_dst ? dsel_q  : ssel_q;
  assign cur_inv  = wr_dst ? dinv_q  : sinv_q;

  assign all_ones    = (cur_spec[IRW-1:0] == '0);
  assign int_rd_addr = cur_spec[IRW-1:0];
  assign int_rd_en   = fetching && !cr_q && !all_ones;
  assign wr_int      = fetching && !cr_q;

  assign cr_rd_addr  = CRW'(cur_spec) + CRW'(elem_q);
  assign cr_rd_en    = fetching && cr_q && (vl_q != '0);
  assign wr_cr       = cr_rd_en;
  assign cr_bit      = cr_pick(cr_rd_data, cur_sel, cur_inv);

  assign step_last = !cr_q || (vl_q == '0) || (elem_q == vl_q - 1'b1);
  assign elem      = elem_q;
  assign vl_eff    = vl_q;
  assign twin_eff  = twin_q;
  assign fin       = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (start) state_d = ST_FETCH_SRC;
      ST_FETCH_SRC: if (step_last) state_d = twin_q ? ST_FETCH_DST : ST_DONE;
      ST_FETCH_DST: if (step_last) state_d = ST_DONE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      vl_q    <= '0;
      cr_q    <= 1'b0;
      twin_q  <= 1'b0;
      sspec_q <= '0;
      dspec_q <= '0;
      ssel_q  <= '0;
      dsel_q  <= '0;
      sinv_q  <= 1'b0;
      dinv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        elem_q  <= '0;
        vl_q    <= (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;
        cr_q    <= use_cr;
        twin_q  <= twin;
        sspec_q <= src_spec;
        dspec_q <= dst_spec;
        ssel_q  <= src_sel;
        dsel_q  <= dst_sel;
        sinv_q  <= src_inv;
        dinv_q  <= dst_inv;
      end else if (fetching) begin
        elem_q <= step_last ? '0 : elem_q + 1'b1;
      end
    end
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_rd_en && cr_rd_en)); // R2
  AST_NO_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd_en |-> (int_rd_addr != '0)); // R4
  AST_CR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_en && $past(cr_rd_en) && (wr_dst == $past(wr_dst)))
      |-> (cr_rd_addr == $past(cr_rd_addr) + 1'b1)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin); // R8
endmodule

// File: rtl/pmf_assemble.sv
module pmf_assemble #(
  parameter int MAX_VL = 16,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [VLW-1:0]    vl_eff,
  input  logic              twin_eff,
  input  logic              fin,
  input  logic              wr_int,
  input  logic              wr_cr,
  input  logic              wr_dst,
  input  logic              all_ones,
  input  logic [MAX_VL-1:0] int_word,
  input  logic              cr_bit,
  input  logic [VLW-1:0]    elem,
  output logic [MAX_VL-1:0] src_mask,
  output logic [MAX_VL-1:0] dst_mask
);
  function automatic logic [MAX_VL-1:0] vl_mask(input logic [VLW-1:0] n);
    logic [MAX_VL-1:0] m;
    for (int i = 0; i < MAX_VL; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic [MAX_VL-1:0] src_q, dst_q, int_val, cr_src, cr_dst;

  assign int_val = (all_ones ? {MAX_VL{1'b1}} : int_word) & vl_mask(vl_eff);
  assign cr_src  = src_q | ((MAX_VL'(cr_bit) << elem) & vl_mask(vl_eff));
  assign cr_dst  = dst_q | ((MAX_VL'(cr_bit) << elem) & vl_mask(vl_eff));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (accept) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (wr_int) begin
      if (wr_dst) dst_q <= int_val;
      else begin
        src_q <= int_val;
        if (!twin_eff) dst_q <= int_val;
      end
    end else if (wr_cr) begin
      if (wr_dst) dst_q <= cr_dst;
      else begin
        src_q <= cr_src;
        if (!twin_eff) dst_q <= cr_src;
      end
    end
  end

  assign src_mask = src_q;
  assign dst_mask = dst_q;

  AST_ABOVE_VL: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (((src_q | dst_q) & ~vl_mask(vl_eff)) == '0)); // R7
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !twin_eff) |-> (dst_q == src_q)); // R6
endmodule

// File: rtl/pred_mask_fetch.sv
module pred_mask_fetch #(
  parameter int MAX_VL = 16,
  parameter int XLEN   = 64,
  parameter int IRW    = 5,
  parameter int CRW    = 6,
  parameter int SPW    = (IRW > CRW) ? IRW : CRW,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_cr,
  input  logic              twin,
  input  logic [VLW-1:0]    vl,
  input  logic [SPW-1:0]    src_spec,
  input  logic [1:0]        src_sel,
  input  logic              src_inv,
  input  logic [SPW-1:0]    dst_spec,
  input  logic [1:0]        dst_sel,
  input  logic              dst_inv,
  output logic              int_rd_en,
  output logic [IRW-1:0]    int_rd_addr,
  input  logic [XLEN-1:0]   int_rd_data,
  output logic              cr_rd_en,
  output logic [CRW-1:0]    cr_rd_addr,
  input  logic [3:0]        cr_rd_data,
  output logic [MAX_VL-1:0] src_mask,
  output logic [MAX_VL-1:0] dst_mask,
  output logic              done
);
  logic           accept, twin_eff, wr_int, wr_cr, wr_dst, all_ones, cr_bit, fin;
  logic [VLW-1:0] vl_eff, elem;

  pmf_ctrl #(.MAX_VL(MAX_VL), .IRW(IRW), .CRW(CRW), .SPW(SPW), .VLW(VLW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .use_cr(use_cr), .twin(twin), .vl(vl),
    .src_spec(src_spec), .src_sel(src_sel), .src_inv(src_inv),
    .dst_spec(dst_spec), .dst_sel(dst_sel), .dst_inv(dst_inv),
    .cr_rd_data(cr_rd_data), .int_rd_en(int_rd_en), .int_rd_addr(int_rd_addr),
    .cr_rd_en(cr_rd_en), .cr_rd_addr(cr_rd_addr), .accept(accept), .vl_eff(vl_eff),
    .twin_eff(twin_eff), .wr_int(wr_int), .wr_cr(wr_cr), .wr_dst(wr_dst),
    .all_ones(all_ones), .cr_bit(cr_bit), .elem(elem), .fin(fin)
  );

  pmf_assemble #(.MAX_VL(MAX_VL), .VLW(VLW)) asm_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .vl_eff(vl_eff), .twin_eff(twin_eff),
    .fin(fin), .wr_int(wr_int), .wr_cr(wr_cr), .wr_dst(wr_dst), .all_ones(all_ones),
    .int_word(int_rd_data[MAX_VL-1:0]), .cr_bit(cr_bit), .elem(elem),
    .src_mask(src_mask), .dst_mask(dst_mask)
  );

  assign done = fin;
endmodule

// File: tb/pred_mask_fetch_tb_top.sv
module pred_mask_fetch_tb_top;
  localparam int MAX_VL = 16, XLEN = 64, IRW = 5, CRW = 6, SPW = 6, VLW = 5;
  localparam int NCR = 1 << CRW;

  logic clk = 0, rst_n = 0;
  logic start = 0, use_cr = 0, twin = 0;
  logic [VLW-1:0] vl = '0;
  logic [SPW-1:0] src_spec = '0, dst_spec = '0;
  logic [1:0] src_sel = '0, dst_sel = '0;
  logic src_inv = 0, dst_inv = 0;
  logic int_rd_en, cr_rd_en, done;
  logic [IRW-1:0] int_rd_addr;
  logic [CRW-1:0] cr_rd_addr;
  logic [XLEN-1:0] int_rd_data;
  logic [3:0] cr_rd_data;
  logic [MAX_VL-1:0] src_mask, dst_mask;

  logic [XLEN-1:0] iregs [32];
  logic [3:0] crf [NCR];
  int n_checks = 0, n_err = 0, n_ird = 0, n_crd = 0;

  always #2.5 clk = ~clk;

  assign int_rd_data = iregs[int_rd_addr];
  assign cr_rd_data  = crf[cr_rd_addr];

  always @(posedge clk) begin
    if (int_rd_en) n_ird++;
    if (cr_rd_en)  n_crd++;
  end

  pred_mask_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .use_cr(use_cr), .twin(twin), .vl(vl),
    .src_spec(src_spec), .src_sel(src_sel), .src_inv(src_inv),
    .dst_spec(dst_spec), .dst_sel(dst_sel), .dst_inv(dst_inv),
    .int_rd_en(int_rd_en), .int_rd_addr(int_rd_addr), .int_rd_data(int_rd_data),
    .cr_rd_en(cr_rd_en), .cr_rd_addr(cr_rd_addr), .cr_rd_data(cr_rd_data),
    .src_mask(src_mask), .dst_mask(dst_mask), .done(done)
  );

  initial begin
    #400000;
    n_checks++; n_err++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [MAX_VL-1:0] lowbits(input int n);
    logic [MAX_VL-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [MAX_VL-1:0] exp_int(input int spec, input int n);
    if ((spec % 32) == 0) return lowbits(n);
    return iregs[spec % 32][MAX_VL-1:0] & lowbits(n);
  endfunction

  function automatic logic [MAX_VL-1:0] exp_cr(input int base, input int sel, input bit inv, input int n);
    logic [MAX_VL-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = crf[(base + i) % NCR][3 - sel] ^ inv;
    return m;
  endfunction

  // drive one fetch, then check masks, latency, read counts, pulse width, hold
  task automatic run(input string tag, input bit c, input bit tw, input int n,
                     input int ss, input int sl, input bit si,
                     input int ds, input int dl, input bit di,
                     input logic [MAX_VL-1:0] es, input logic [MAX_VL-1:0] ed,
                     input int elat, input int eird, input int ecrd, input bit busy_poke);
    int lat;
    logic [MAX_VL-1:0] hs, hd;
    @(negedge clk);
    use_cr = c; twin = tw; vl = VLW'(n);
    src_spec = SPW'(ss); src_sel = 2'(sl); src_inv = si;
    dst_spec = SPW'(ds); dst_sel = 2'(dl); dst_inv = di;
    n_ird = 0; n_crd = 0; start = 1; lat = 0;
    @(posedge clk); lat++;
    @(negedge clk); start = 0;
    if (busy_poke) begin
      use_cr = ~c; vl = VLW'(3); src_spec = SPW'(9); src_sel = 2'd3; src_inv = ~si;
      start = 1;
    end
    while (!done && lat < 200) begin
      @(posedge clk); lat++;
      @(negedge clk); start = 0;
    end
    chk({tag, " src_mask"}, 64'(src_mask), 64'(es));
    chk({tag, " dst_mask"}, 64'(dst_mask), 64'(ed));
    chk({tag, " latency"}, 64'(lat), 64'(elat));
    chk({tag, " int reads"}, 64'(n_ird), 64'(eird));
    chk({tag, " cr reads"}, 64'(n_crd), 64'(ecrd));
    hs = src_mask; hd = dst_mask;
    @(negedge clk);
    chk("R8 done pulse width", 64'(done), 64'd0);
    repeat (4) @(negedge clk);
    chk("R8 masks held", 64'({src_mask, dst_mask}), 64'({hs, hd}));
  endtask

  task automatic t_reset;
    chk("R1 done", 64'(done), 0);
    chk("R1 masks", 64'({src_mask, dst_mask}), 0);
    chk("R1 read enables", 64'({int_rd_en, cr_rd_en}), 0);
  endtask

  task automatic t_int_single;   // R2 R6 R7
    run("R2 int single vl10", 0, 0, 10, 7, 0, 0, 3, 0, 0,
        exp_int(7, 10), exp_int(7, 10), 2, 1, 0, 0);
  endtask

  task automatic t_int_zero;     // R4, specifier 32 has low bits zero
    run("R4 int always", 0, 0, 16, 0, 0, 0, 0, 0, 0, lowbits(16), lowbits(16), 2, 0, 0, 0);
    run("R4 int always spec32 vl5", 0, 0, 5, 32, 0, 0, 0, 0, 0, lowbits(5), lowbits(5), 2, 0, 0, 0);
  endtask

  task automatic t_int_twin;     // R5
    run("R5 int twin", 0, 1, 16, 4, 0, 0, 11, 0, 0,
        exp_int(4, 16), exp_int(11, 16), 3, 2, 0, 0);
    run("R5 int twin dst always", 0, 1, 12, 5, 0, 0, 0, 0, 0,
        exp_int(5, 12), lowbits(12), 3, 1, 0, 0);
  endtask

  task automatic t_cr_single;    // R3 R6
    run("R3 cr single EQ vl8", 1, 0, 8, 10, 2, 0, 0, 0, 0,
        exp_cr(10, 2, 0, 8), exp_cr(10, 2, 0, 8), 9, 0, 8, 0);
    run("R3 cr single GT inv vl16", 1, 0, 16, 30, 1, 1, 0, 0, 0,
        exp_cr(30, 1, 1, 16), exp_cr(30, 1, 1, 16), 17, 0, 16, 0);
  endtask

  task automatic t_cr_twin;      // R3 R5 with field wrap-around
    run("R5 cr twin wrap", 1, 1, 5, 20, 0, 1, 62, 3, 0,
        exp_cr(20, 0, 1, 5), exp_cr(62, 3, 0, 5), 11, 0, 10, 0);
  endtask

  task automatic t_vl_zero;      // R7
    run("R7 cr vl0", 1, 1, 0, 3, 0, 1, 4, 1, 1, '0, '0, 3, 0, 0, 0);
    run("R7 int vl0", 0, 0, 0, 0, 0, 0, 0, 0, 0, '0, '0, 2, 0, 0, 0);
    run("R7 int vl1", 0, 0, 1, 6, 0, 0, 0, 0, 0, exp_int(6, 1), exp_int(6, 1), 2, 1, 0, 0);
  endtask

  task automatic t_busy;         // R9
    run("R9 start while busy", 1, 0, 6, 40, 3, 0, 0, 0, 0,
        exp_cr(40, 3, 0, 6), exp_cr(40, 3, 0, 6), 7, 0, 6, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      iregs[i] = (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1)) ^ 64'(i * 3);
    for (int i = 0; i < NCR; i++) crf[i] = 4'((i * 7 + 3) ^ (i >> 2));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_int_single();
    t_int_zero();
    t_int_twin();
    t_cr_single();
    t_cr_twin();
    t_vl_zero();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule